// File: doc/BRIEF.md
# Rearrangeable Permutation Switch with Hardware Looping Router

This block connects N input ports to N output ports through a rearrangeable multistage network of 2x2 exchange elements. Each element is either straight or crossed. The network is built recursively. An outer input column and an outer output column of N/2 elements each surround two half-size copies of the network, an upper one and a lower one. The recursion ends in a middle column of single elements, which gives 2·log2N−1 columns in total.

A sequential routing engine sets every element. A caller supplies a complete permutation, giving the destination port of every input, and pulses a start strobe. The engine then works level by level. It picks an unassigned input, sends it to the upper half, and forces the input that shares its output element into the lower half. The partner of that input then goes upper, and the walk goes on until the constraint cycle closes. Each subnetwork is finished this way before the induced half-size permutations are routed in the same manner. One constraint step takes one cycle.

When the engine finishes, the new element settings replace the active ones in a single cycle. Throughout, the datapath moves one word per port per cycle through a registered output stage.

Top module: `benes_switch`

## Requirements
- R1: After a successful routing run, a word applied on input k appears on output perm(k), for every k, with all N words delivered in the same cycle.
- R2: Destination ports are numbered from 0. The destination of input k is held in perm_i bits [k*log2N +: log2N].
- R3: data_o is registered. A word applied on data_i in one cycle is visible on data_o after the next rising clock edge, and consecutive cycles carry independent words.
- R4: A valid run raises done_o no more than 2·N·log2N+4 cycles after the start strobe is accepted.
- R5: A start strobe is accepted only while busy_o is low. Strobes while busy are ignored, and the run in progress routes the permutation loaded first.
- R6: busy_o is high from the cycle after an accepted start until the done cycle. done_o is a single-cycle pulse, and busy_o is low in the cycle after it.
- R7: A permutation that names some output twice raises err_o together with done_o. The active routing stays unchanged, and err_o holds until the next accepted start. A valid run clears err_o.
- R8: The active element settings change only at the clock edge that ends the done cycle of a valid run. Traffic applied while a run is in progress is routed by the previous settings.
- R9: During reset, data_o is zero and busy_o, done_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load perm_i and start routing |
| perm_i | input | N_PORTS*log2(N_PORTS) | Destination port per input |
| data_i | input | N_PORTS*DATA_W | One word per input port |
| busy_o | output | 1 | Routing engine running |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Last loaded permutation was not a bijection |
| data_o | output | N_PORTS*DATA_W | Registered switched words, one per output |

## Verification
The datapath keeps switching words while the routing engine is computing a new set of element states. The hazard is the handover cycle, when done_o is high and the next edge swaps the settings. The bench streams freshly tagged words on every cycle while a second permutation is being routed. Each word is judged against the mapping that should be active when it is captured: the old one up to and including the done cycle, and the new one afterwards.

// File: rtl/benes_pkg.sv
package benes_pkg;
  typedef enum logic [1:0] {RT_IDLE, RT_SEEK, RT_STEP, RT_FIN} rt_state_e;
endpackage

// File: rtl/benes_elem.sv
module benes_elem #(
  parameter int W = 8
) (
  input  logic         sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o
);
  // sel 0: straight, sel 1: crossed
  assign x_o = sel_i ? b_i : a_i;
  assign y_o = sel_i ? a_i : b_i;
endmodule

// File: rtl/benes_fabric.sv
module benes_fabric #(
  parameter int N  = 8,
  parameter int W  = 8,
  localparam int LG = $clog2(N),
  localparam int H  = N / 2
) (
  input  logic [(LG-1)*H-1:0] cin_i,
  input  logic [(LG-1)*H-1:0] cout_i,
  input  logic [H-1:0]        cmid_i,
  input  logic [N*W-1:0]      data_i,
  output logic [N*W-1:0]      data_o
);
  logic [W-1:0] dn  [LG][N];
  logic [W-1:0] upw [LG][N];

  for (genvar k = 0; k < N; k++) begin : g_io
    assign dn[0][k]          = data_i[k*W +: W];
    assign data_o[k*W +: W]  = upw[0][k];
  end

  for (genvar d = 0; d < LG-1; d++) begin : g_lvl
    localparam int M  = N >> d;
    localparam int HM = M / 2;
    for (genvar q = 0; q < H; q++) begin : g_el
      localparam int B = q / HM;
      localparam int J = q % HM;
      benes_elem #(.W(W)) u_in (
        .sel_i(cin_i[d*H+q]),
        .a_i(dn[d][2*q]), .b_i(dn[d][2*q+1]),
        .x_o(dn[d+1][B*M+J]), .y_o(dn[d+1][B*M+HM+J])
      );
      benes_elem #(.W(W)) u_out (
        .sel_i(cout_i[d*H+q]),
        .a_i(upw[d+1][B*M+J]), .b_i(upw[d+1][B*M+HM+J]),
        .x_o(upw[d][2*q]), .y_o(upw[d][2*q+1])
      );
    end
  end

  for (genvar q = 0; q < H; q++) begin : g_mid
    benes_elem #(.W(W)) u_mid (
      .sel_i(cmid_i[q]),
      .a_i(dn[LG-1][2*q]), .b_i(dn[LG-1][2*q+1]),
      .x_o(upw[LG-1][2*q]), .y_o(upw[LG-1][2*q+1])
    );
  end
endmodule

// File: rtl/benes_router.sv
module benes_router
  import benes_pkg::*;
#(
  parameter int N  = 8,
  localparam int LG = $clog2(N),
  localparam int H  = N / 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [N*LG-1:0]     perm_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic [(LG-1)*H-1:0] cin_o,
  output logic [(LG-1)*H-1:0] cout_o,
  output logic [H-1:0]        cmid_o
);
  rt_state_e         st_q;
  logic [LG-1:0]     lvl_q, sub_q, cur_q;
  logic [LG-1:0]     perm_q  [N];
  logic [LG-1:0]     nperm_q [N];
  logic [H-1:0]      asg_q;
  logic [(LG-1)*H-1:0] cin_q, cout_q;
  logic [H-1:0]      cmid_q;
  logic              err_q;

  logic [LG-1:0] mask, half, base_cur, li, li2, pd, i2, gout, sub_base;
  logic [LG-1:0] up_pos, lo_pos;
  logic [LG-2:0] e_cur, i2e, ko, fe;
  logic          found, last_sub, closed, perm_ok;
  logic [N-1:0]  hit;

  always_comb begin
    mask     = LG'((N >> lvl_q) - 1);
    half     = LG'(N >> (lvl_q + 1));
    base_cur = cur_q & ~mask;
    li       = cur_q & mask;
    pd       = perm_q[cur_q];
    gout     = base_cur | pd;
    ko       = gout[LG-1:1];
    e_cur    = cur_q[LG-1:1];
    i2       = '0;
    for (int p = 0; p < N; p++)
      if (((LG'(p) & ~mask) == base_cur) && (perm_q[p] == (pd ^ LG'(1))))
        i2 = LG'(p);
    li2      = i2 & mask;
    i2e      = i2[LG-1:1];
    closed   = asg_q[i2e] || (i2e == e_cur);
    up_pos   = base_cur | (li >> 1);
    lo_pos   = base_cur | half | (li2 >> 1);
    sub_base = sub_q << (LG - lvl_q);
    last_sub = (sub_q == LG'((1 << lvl_q) - 1));
    found    = 1'b0;
    fe       = '0;
    for (int e = H-1; e >= 0; e--)
      if (!asg_q[e] && ((LG'(2*e) & ~mask) == sub_base)) begin
        found = 1'b1;
        fe    = (LG-1)'(e);
      end
    hit = '0;
    for (int k = 0; k < N; k++) hit[perm_i[k*LG +: LG]] = 1'b1;
    perm_ok = &hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RT_IDLE;
      lvl_q  <= '0;
      sub_q  <= '0;
      cur_q  <= '0;
      asg_q  <= '0;
      cin_q  <= '0;
      cout_q <= '0;
      cmid_q <= '0;
      err_q  <= 1'b0;
      for (int p = 0; p < N; p++) begin
        perm_q[p]  <= '0;
        nperm_q[p] <= '0;
      end
    end else begin
      unique case (st_q)
        RT_IDLE: if (start_i) begin
          for (int k = 0; k < N; k++) perm_q[k] <= perm_i[k*LG +: LG];
          lvl_q <= '0;
          sub_q <= '0;
          asg_q <= '0;
          err_q <= !perm_ok;
          st_q  <= perm_ok ? RT_SEEK : RT_FIN;
        end
        RT_SEEK: begin
          if (lvl_q == LG'(LG-1)) begin
            for (int q = 0; q < H; q++) cmid_q[q] <= perm_q[2*q][0];
            st_q <= RT_FIN;
          end else if (found) begin
            cur_q <= {fe, 1'b0};
            st_q  <= RT_STEP;
          end else if (last_sub) begin
            for (int p = 0; p < N; p++) perm_q[p] <= nperm_q[p];
            lvl_q <= lvl_q + 1'b1;
            sub_q <= '0;
            asg_q <= '0;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        RT_STEP: begin
          // current input goes upper; sharer of its output element goes lower
          asg_q[e_cur]    <= 1'b1;
          nperm_q[up_pos] <= pd >> 1;
          nperm_q[lo_pos] <= pd >> 1;
          for (int l = 0; l < LG-1; l++)
            for (int e = 0; e < H; e++) begin
              if (lvl_q == LG'(l) && e_cur == (LG-1)'(e)) cin_q[l*H+e]  <= li[0];
              if (lvl_q == LG'(l) && ko == (LG-1)'(e))    cout_q[l*H+e] <= pd[0];
            end
          if (closed) st_q <= RT_SEEK;
          else        cur_q <= {i2[LG-1:1], ~i2[0]};
        end
        RT_FIN: st_q <= RT_IDLE;
        default: st_q <= RT_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != RT_IDLE);
  assign done_o = (st_q == RT_FIN);
  assign err_o  = err_q;
  assign cin_o  = cin_q;
  assign cout_o = cout_q;
  assign cmid_o = cmid_q;

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_step_fresh_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RT_STEP) |-> !asg_q[e_cur]);
  assert_err_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && st_q == RT_IDLE) |=> $stable(err_o));
  assert_busy_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/benes_switch.sv
module benes_switch #(
  parameter int N_PORTS = 8,
  parameter int DATA_W  = 8,
  localparam int LG = $clog2(N_PORTS),
  localparam int H  = N_PORTS / 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [N_PORTS*LG-1:0]     perm_i,
  input  logic [N_PORTS*DATA_W-1:0] data_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      err_o,
  output logic [N_PORTS*DATA_W-1:0] data_o
);
  logic [(LG-1)*H-1:0] rt_cin, rt_cout, act_cin, act_cout;
  logic [H-1:0]        rt_cmid, act_cmid;
  logic [N_PORTS*DATA_W-1:0] sw_data;

  benes_router #(.N(N_PORTS)) u_router (
    .clk_i, .rst_ni, .start_i, .perm_i,
    .busy_o, .done_o, .err_o,
    .cin_o(rt_cin), .cout_o(rt_cout), .cmid_o(rt_cmid)
  );

  benes_fabric #(.N(N_PORTS), .W(DATA_W)) u_fabric (
    .cin_i(act_cin), .cout_i(act_cout), .cmid_i(act_cmid),
    .data_i, .data_o(sw_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_cin  <= '0;
      act_cout <= '0;
      act_cmid <= '0;
      data_o   <= '0;
    end else begin
      if (done_o && !err_o) begin
        act_cin  <= rt_cin;
        act_cout <= rt_cout;
        act_cmid <= rt_cmid;
      end
      data_o <= sw_data;
    end
  end

  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && !err_o) |=> ($stable(act_cin) && $stable(act_cout) && $stable(act_cmid)));
  assert_accept_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: tb/sim_benes_switch.sv
module sim_benes_switch;
  localparam int N = 8, LG = 3, W = 8;
  localparam int BOUND = 2*N*LG + 4;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [N*LG-1:0] perm_i = '0;
  logic [N*W-1:0]  data_i = '0;
  logic busy_o, done_o, err_o;
  logic [N*W-1:0] data_o;

  int checks = 0, fails = 0;

  benes_switch #(.N_PORTS(N), .DATA_W(W)) u0 (
    .clk_i(clk), .rst_ni, .start_i, .perm_i, .data_i,
    .busy_o, .done_o, .err_o, .data_o
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pack(input int pm[N]);
    for (int k = 0; k < N; k++) perm_i[k*LG +: LG] = LG'(pm[k]);
  endtask

  task automatic run_router(input int pm[N], output int lat, output bit er);
    @(negedge clk);
    pack(pm);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R6 busy after start", busy_o, 1);
    lat = 1;
    while (!done_o && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    er = err_o;
    @(negedge clk);
    chk(!done_o && !busy_o, "R6 done pulse", done_o, 0);
  endtask

  task automatic send_check(input int pm[N], input string req);
    logic [W-1:0] w[N];
    for (int k = 0; k < N; k++) begin
      w[k] = W'((k << 4) | ($urandom & 15));
      data_i[k*W +: W] = w[k];
    end
    @(negedge clk);
    for (int k = 0; k < N; k++)
      chk(data_o[pm[k]*W +: W] == w[k], req, data_o[pm[k]*W +: W], w[k]);
  endtask

  task automatic shuffle(output int pm[N]);
    for (int i = 0; i < N; i++) pm[i] = i;
    for (int i = N-1; i > 0; i--) begin
      int j, t;
      j = $urandom_range(i, 0);
      t = pm[i]; pm[i] = pm[j]; pm[j] = t;
    end
  endtask

  task automatic full_route(input int pm[N], input string req);
    int lat; bit er;
    run_router(pm, lat, er);
    chk(lat <= BOUND, "R4 latency", lat, BOUND);
    chk(!er, "R7 valid run clears err", er, 0);
    send_check(pm, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int pa[N], pb[N], pm[N], lat;
    bit er;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(data_o == '0, "R9 data reset", int'(data_o[31:0]), 0);
    chk(!busy_o && !done_o && !err_o, "R9 flags reset", {busy_o, done_o, err_o}, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < N; i++) pm[i] = i;
    full_route(pm, "R1 identity");
    for (int i = 0; i < N; i++) pm[i] = N-1-i;
    full_route(pm, "R1 reversal");
    pm = '{0, 4, 5, 7, 3, 1, 2, 6};
    full_route(pm, "R1/R2 reference permutation");
    for (int i = 0; i < N; i++) pm[i] = i ^ 1;
    full_route(pm, "R1 pair swap");
    for (int i = 0; i < N; i++) pm[i] = (i + 1) % N;
    full_route(pm, "R1 rotation");

    for (int r = 0; r < 40; r++) begin
      shuffle(pm);
      full_route(pm, "R1 random");
    end

    // R3: back-to-back words
    begin
      logic [W-1:0] w[N];
      for (int c = 0; c < 4; c++) begin
        for (int k = 0; k < N; k++) begin
          w[k] = W'((k << 4) | ((c * 3 + k) & 15));
          data_i[k*W +: W] = w[k];
        end
        @(negedge clk);
        for (int k = 0; k < N; k++)
          chk(data_o[pm[k]*W +: W] == w[k], "R3 stream", data_o[pm[k]*W +: W], w[k]);
      end
    end

    // R5: strobes while busy are ignored
    shuffle(pa);
    for (int i = 0; i < N; i++) pb[i] = (pa[i] + 3) % N;
    @(negedge clk);
    pack(pa);
    start_i = 1'b1;
    @(negedge clk);
    pack(pb);
    repeat (3) @(negedge clk);
    start_i = 1'b0;
    lat = 4;
    while (!done_o && lat < 1000) begin @(negedge clk); lat++; end
    chk(lat <= BOUND, "R5 latency", lat, BOUND);
    @(negedge clk);
    send_check(pa, "R5 first permutation kept");

    // R7: duplicate destination
    pm = pa;
    pm[2] = pm[5];
    run_router(pm, lat, er);
    chk(er, "R7 err raised", er, 1);
    chk(lat == 1, "R7 immediate done", lat, 1);
    send_check(pa, "R7 routing unchanged");
    repeat (3) @(negedge clk);
    chk(err_o, "R7 err holds", err_o, 1);
    full_route(pa, "R7 recovery");

    // R8: traffic across the handover
    shuffle(pb);
    begin
      logic [W-1:0] w[N];
      bit seen = 0, prev_new = 0, have = 0;
      int post = 0;
      @(negedge clk);
      pack(pb);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int it = 0; it < 200; it++) begin
        if (have)
          for (int k = 0; k < N; k++) begin
            int d;
            d = prev_new ? pb[k] : pa[k];
            chk(data_o[d*W +: W] == w[k], "R8 handover", data_o[d*W +: W], w[k]);
          end
        for (int k = 0; k < N; k++) begin
          w[k] = W'((k << 4) | ($urandom & 15));
          data_i[k*W +: W] = w[k];
        end
        prev_new = seen;
        have = 1;
        if (done_o) seen = 1;
        if (seen) post++;
        if (post > 2) break;
        @(negedge clk);
      end
      @(negedge clk);
      for (int k = 0; k < N; k++)
        chk(data_o[pb[k]*W +: W] == w[k], "R8 new mapping", data_o[pb[k]*W +: W], w[k]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule